// File: doc/BRIEF.md
# UTF-8 Decoder with Latin-1 Fallback

This block turns a byte stream into Unicode code points for a text subsystem. Bytes arrive on a valid/ready input, and one token leaves per decoded character on a valid/ready output. Each token carries the code point, the number of source bytes it used, a flag that marks a Latin-1 fallback token, and an end-of-string flag. Well-formed sequences of one to four bytes are joined into a single code point. The four-byte form is enabled by a parameter.

Malformed input is never dropped and never replaced by a placeholder. Each byte of a broken sequence comes out as its own code point with the same value as the byte, in the order the bytes arrived. The byte that broke a sequence is then decoded again as if it started a new one. A NUL byte, or a byte presented with the end-of-string strobe, flushes any partial sequence in this same way.

Two running counters hold the character count and the byte count of the current string. A caret or length routine can read the logical length and the physical length side by side.

Top module: `utf8_latin_dec`

## Requirements
- R1: A byte from 0x00 to 0x7F gives one token with the same code point, byte count 1 and fallback flag 0.
- R2: A lead from 0xC2 to 0xDF followed by one continuation (0x80 to 0xBF) gives one token with byte count 2. A lead from 0xE0 to 0xEF followed by two continuations gives one token with byte count 3. The code point is the payload bits joined in order, and the fallback flag is 0.
- R3: With MAX_LEN = 4, a lead from 0xF0 to 0xF4 followed by three continuations gives one token with byte count 4.
- R4: A stray continuation byte, or a byte 0xC0, 0xC1 or 0xF5 to 0xFF, gives one token whose code point equals the byte, with byte count 1 and fallback flag 1.
- R5: Some second bytes are rejected: after 0xE0 anything below 0xA0 (overlong), after 0xED anything above 0x9F (surrogate), after 0xF0 anything below 0x90 (overlong), and after 0xF4 anything above 0x8F (beyond U+10FFFF). In each case the lead comes out as a Latin-1 token, and the rejected byte is then decoded again on its own.
- R6: When a byte that is not a continuation interrupts a sequence, the bytes already held come out first as Latin-1 tokens in arrival order. The interrupting byte is then decoded as a new lead.
- R7: A NUL byte flushes any held bytes as Latin-1. The NUL then comes out as U+0000 with the end flag set.
- R8: A byte presented with in_last that leaves a sequence unfinished flushes all held bytes, including itself, as Latin-1 tokens. Only the final one of these tokens carries the end flag.
- R9: Every token has a byte count of at least 1. A fallback token has a byte count of exactly 1 and a code point no greater than 0xFF.
- R10: While out_valid is high and out_ready is low, every output field holds its value.
- R11: When a token is accepted, char_count rises by one and byte_count rises by that token's byte count. The first token accepted after a token with the end flag restarts both counts at that token's own values.
- R12: A token with fallback flag 0 never carries an overlong value, a surrogate, or a value above 0x10FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Input byte is taken on this edge |
| in_byte | input | 8 | Source byte |
| in_last | input | 1 | The byte ends the string |
| out_valid | output | 1 | Output token is present |
| out_ready | input | 1 | Consumer takes the token |
| out_cp | output | 21 | Unicode code point |
| out_nbytes | output | 3 | Source bytes used by the token |
| out_fallback | output | 1 | Token is a Latin-1 replay of one byte |
| out_last | output | 1 | Token ends the string |
| char_count | output | CNT_W | Characters in the current string |
| byte_count | output | CNT_W | Bytes in the current string |

## Verification
The hardest case to reach from the ports is the one where a sequence breaks after several bytes are already held. Several things must then happen in a fixed order: the held bytes replay, the input stalls, and the interrupting byte is decoded again. The bench drives a three-byte lead and one good continuation, then a plain ASCII byte or a NUL. It then checks the full order of tokens and their flags.

A second hard case is a byte that ends the string in the middle of a sequence. The bench drives this with a truncated sequence whose last byte carries the end strobe, and checks that only the final replayed token carries the end flag. Backpressure is tested by holding out_ready low while a token waits.

// File: rtl/utf8_pkg.sv
package utf8_pkg;
   typedef enum logic [1:0] {
      BC_ASCII = 2'd0,
      BC_LEAD  = 2'd1,
      BC_CONT  = 2'd2,
      BC_BAD   = 2'd3
   } byte_cls_e;

   localparam int CP_W = 21;
   localparam int NB_W = 3;
endpackage

// File: rtl/utf8_byte_class.sv
module utf8_byte_class
   import utf8_pkg::*;
#(
   parameter int MAX_LEN = 4
) (
   input  logic [7:0]      b,
   output byte_cls_e       cls,
   output logic [NB_W-1:0] seq_len
);
   logic four_ok;

   generate
      if (MAX_LEN == 4) begin : g_four
         assign four_ok = 1'b1;
      end else begin : g_three
         assign four_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cls     = BC_BAD;
      seq_len = 3'd1;
      if (b < 8'h80) begin
         cls = BC_ASCII;
      end else if (b < 8'hC0) begin
         cls = BC_CONT;
      end else if (b >= 8'hC2 && b <= 8'hDF) begin
         cls     = BC_LEAD;
         seq_len = 3'd2;
      end else if (b >= 8'hE0 && b <= 8'hEF) begin
         cls     = BC_LEAD;
         seq_len = 3'd3;
      end else if (b >= 8'hF0 && b <= 8'hF4 && four_ok) begin
         cls     = BC_LEAD;
         seq_len = 3'd4;
      end
   end
endmodule

// File: rtl/utf8_second_check.sv
module utf8_second_check (
   input  logic [7:0] lead,
   input  logic [7:0] nxt,
   output logic       ok
);
   logic [7:0] lo, hi;

   always_comb begin
      lo = 8'h80;
      hi = 8'hBF;
      case (lead)
         8'hE0:   lo = 8'hA0;
         8'hED:   hi = 8'h9F;
         8'hF0:   lo = 8'h90;
         8'hF4:   hi = 8'h8F;
         default: ;
      endcase
      ok = (nxt >= lo) && (nxt <= hi);
   end
endmodule

// File: rtl/utf8_cp_join.sv
module utf8_cp_join
   import utf8_pkg::*;
(
   input  logic [7:0]      b0,
   input  logic [7:0]      b1,
   input  logic [7:0]      b2,
   input  logic [7:0]      bl,
   input  logic [NB_W-1:0] len,
   output logic [CP_W-1:0] cp
);
   always_comb begin
      case (len)
         3'd2:    cp = {10'd0, b0[4:0], bl[5:0]};
         3'd3:    cp = {5'd0, b0[3:0], b1[5:0], bl[5:0]};
         3'd4:    cp = {b0[2:0], b1[5:0], b2[5:0], bl[5:0]};
         default: cp = {13'd0, bl};
      endcase
   end
endmodule

// File: rtl/utf8_len_count.sv
module utf8_len_count
   import utf8_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok,
   input  logic [NB_W-1:0]  nb,
   input  logic             last,
   output logic [CNT_W-1:0] chars,
   output logic [CNT_W-1:0] bytes
);
   logic restart_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chars     <= '0;
         bytes     <= '0;
         restart_q <= 1'b0;
      end else if (tok) begin
         restart_q <= last;
         if (restart_q) begin
            chars <= CNT_W'(1);
            bytes <= CNT_W'(nb);
         end else begin
            chars <= chars + CNT_W'(1);
            bytes <= bytes + CNT_W'(nb);
         end
      end
   end
endmodule

// File: rtl/utf8_latin_dec.sv
module utf8_latin_dec
   import utf8_pkg::*;
#(
   parameter int MAX_LEN = 4,
   parameter int CNT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_byte,
   input  logic             in_last,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [20:0]      out_cp,
   output logic [2:0]       out_nbytes,
   output logic             out_fallback,
   output logic             out_last,
   output logic [CNT_W-1:0] char_count,
   output logic [CNT_W-1:0] byte_count
);
   localparam int HOLD = MAX_LEN - 1;

   generate
      if (MAX_LEN != 3 && MAX_LEN != 4) begin : g_bad_len
         $error("MAX_LEN must be 3 or 4");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
   endgenerate

   logic [7:0]      hold_q [3];
   logic [1:0]      pend_q;
   logic [2:0]      need_q;
   logic            replay_q;
   logic [1:0]      rp_idx_q;
   logic            rp_last_q;

   byte_cls_e       cls;
   logic [NB_W-1:0] seq_len;
   logic            sec_ok, cont_ok, complete, slot_free;
   logic [CP_W-1:0] joined;

   logic            emit, push, start_rp, rp_last_n;
   logic [CP_W-1:0] e_cp;
   logic [NB_W-1:0] e_nb;
   logic            e_fb, e_last;

   utf8_byte_class #(.MAX_LEN(MAX_LEN)) i_cls (
      .b(in_byte), .cls(cls), .seq_len(seq_len)
   );

   utf8_second_check i_sec (
      .lead(hold_q[0]), .nxt(in_byte), .ok(sec_ok)
   );

   utf8_cp_join i_join (
      .b0(hold_q[0]), .b1(hold_q[1]), .b2(hold_q[2]), .bl(in_byte),
      .len(need_q), .cp(joined)
   );

   assign slot_free = !out_valid || out_ready;
   assign cont_ok   = (pend_q == 2'd1) ? sec_ok : (in_byte[7:6] == 2'b10);
   assign complete  = ({1'b0, pend_q} + 3'd1) == need_q;
   assign in_ready  = slot_free && !replay_q && (pend_q == 2'd0 || cont_ok);

   always_comb begin
      emit      = 1'b0;
      push      = 1'b0;
      start_rp  = 1'b0;
      rp_last_n = 1'b0;
      e_cp      = {13'd0, in_byte};
      e_nb      = 3'd1;
      e_fb      = 1'b0;
      e_last    = 1'b0;
      if (slot_free) begin
         if (replay_q) begin
            emit   = 1'b1;
            e_cp   = {13'd0, hold_q[rp_idx_q]};
            e_fb   = 1'b1;
            e_last = rp_last_q && (rp_idx_q == pend_q - 2'd1);
         end else if (in_valid) begin
            if (pend_q == 2'd0) begin
               case (cls)
                  BC_ASCII: begin
                     emit   = 1'b1;
                     e_last = in_last || (in_byte == 8'h00);
                  end
                  BC_LEAD: begin
                     if (in_last) begin
                        emit   = 1'b1;
                        e_fb   = 1'b1;
                        e_last = 1'b1;
                     end else begin
                        push = 1'b1;
                     end
                  end
                  default: begin
                     emit   = 1'b1;
                     e_fb   = 1'b1;
                     e_last = in_last;
                  end
               endcase
            end else if (!cont_ok) begin
               start_rp = 1'b1;
            end else if (complete) begin
               emit   = 1'b1;
               e_cp   = joined;
               e_nb   = need_q;
               e_last = in_last;
            end else begin
               push = 1'b1;
               if (in_last) begin
                  start_rp  = 1'b1;
                  rp_last_n = 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) hold_q[i] <= '0;
         pend_q    <= '0;
         need_q    <= 3'd1;
         replay_q  <= 1'b0;
         rp_idx_q  <= '0;
         rp_last_q <= 1'b0;
      end else begin
         if (push) begin
            hold_q[pend_q] <= in_byte;
            pend_q         <= pend_q + 2'd1;
            if (pend_q == 2'd0) need_q <= seq_len;
         end
         if (start_rp) begin
            replay_q  <= 1'b1;
            rp_idx_q  <= '0;
            rp_last_q <= rp_last_n;
         end
         if (replay_q && emit) begin
            if (rp_idx_q == pend_q - 2'd1) begin
               replay_q <= 1'b0;
               pend_q   <= '0;
            end else begin
               rp_idx_q <= rp_idx_q + 2'd1;
            end
         end
         if (!replay_q && emit && pend_q != 2'd0) pend_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_cp       <= '0;
         out_nbytes   <= 3'd1;
         out_fallback <= 1'b0;
         out_last     <= 1'b0;
      end else if (emit) begin
         out_valid    <= 1'b1;
         out_cp       <= e_cp;
         out_nbytes   <= e_nb;
         out_fallback <= e_fb;
         out_last     <= e_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   utf8_len_count #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tok(out_valid && out_ready),
      .nb(out_nbytes), .last(out_last),
      .chars(char_count), .bytes(byte_count)
   );

   logic unused_hold;
   assign unused_hold = (HOLD == 0);
endmodule

// File: rtl/utf8_latin_dec_chk.sv
module utf8_latin_dec_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_ready,
   input logic [20:0]      out_cp,
   input logic [2:0]       out_nbytes,
   input logic             out_fallback,
   input logic             out_last,
   input logic [CNT_W-1:0] char_count,
   input logic [CNT_W-1:0] byte_count
);
   AST_NB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_nbytes != 3'd0 && out_nbytes <= 3'd4)); // R9

   AST_FALLBACK_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fallback) |-> (out_nbytes == 3'd1 && out_cp <= 21'hFF)); // R9

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_cp) && $stable(out_nbytes)
                                     && $stable(out_fallback) && $stable(out_last))); // R10

   AST_NO_SURROGATE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fallback) |-> !(out_cp >= 21'hD800 && out_cp <= 21'hDFFF)); // R12

   AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fallback) |-> out_cp <= 21'h10FFFF); // R12

   AST_NOT_OVERLONG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_fallback && out_nbytes > 3'd1) |->
         ((out_nbytes == 3'd2 && out_cp >= 21'h80) ||
          (out_nbytes == 3'd3 && out_cp >= 21'h800) ||
          (out_nbytes == 3'd4 && out_cp >= 21'h10000))); // R12

   AST_CHARS_LE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      char_count <= byte_count); // R11
endmodule

bind utf8_latin_dec utf8_latin_dec_chk #(.CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
   .out_cp(out_cp), .out_nbytes(out_nbytes), .out_fallback(out_fallback),
   .out_last(out_last), .char_count(char_count), .byte_count(byte_count)
);

// File: tb/test_utf8_latin_dec.sv
module test_utf8_latin_dec;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [7:0]       in_byte = '0;
   logic             in_last = 1'b0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [20:0]      out_cp;
   logic [2:0]       out_nbytes;
   logic             out_fallback;
   logic             out_last;
   logic [CNT_W-1:0] char_count;
   logic [CNT_W-1:0] byte_count;

   int checks = 0;
   int errors = 0;

   logic [20:0] q_cp [0:127];
   logic [2:0]  q_nb [0:127];
   logic        q_fb [0:127];
   logic        q_ls [0:127];
   int          q_n = 0;

   always #10 clk = ~clk;

   utf8_latin_dec #(.MAX_LEN(4), .CNT_W(CNT_W)) i_utf8_latin_dec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_byte(in_byte), .in_last(in_last), .out_valid(out_valid),
      .out_ready(out_ready), .out_cp(out_cp), .out_nbytes(out_nbytes),
      .out_fallback(out_fallback), .out_last(out_last),
      .char_count(char_count), .byte_count(byte_count)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && q_n < 128) begin
         q_cp[q_n] = out_cp;
         q_nb[q_n] = out_nbytes;
         q_fb[q_n] = out_fallback;
         q_ls[q_n] = out_last;
         q_n = q_n + 1;
      end
   end

   task automatic send(input logic [7:0] b, input logic lst);
      in_valid = 1'b1;
      in_byte  = b;
      in_last  = lst;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic drain();
      repeat (8) @(posedge clk);
      #1;
   endtask

   task automatic chk_num(input int base, input int n, input string req);
      checks++;
      if (q_n - base != n) begin
         errors++;
         $display("FAIL %s token count got %0d exp %0d", req, q_n - base, n);
      end
   endtask

   task automatic chk_tok(input int idx, input logic [20:0] cp, input int nb,
                          input logic fb, input logic ls, input string req);
      checks++;
      if (q_cp[idx] !== cp || q_nb[idx] !== 3'(nb) || q_fb[idx] !== fb || q_ls[idx] !== ls) begin
         errors++;
         $display("FAIL %s tok %0d got cp=%h nb=%0d fb=%b last=%b exp cp=%h nb=%0d fb=%b last=%b",
                  req, idx, q_cp[idx], q_nb[idx], q_fb[idx], q_ls[idx], cp, nb, fb, ls);
      end
   endtask

   task automatic chk_val(input int got, input int exp, input string req);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d exp %0d", req, got, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk_val(int'(out_valid), 0, "R11 reset out_valid");
      chk_val(int'(in_ready), 1, "R11 reset in_ready");
      chk_val(int'(char_count), 0, "R11 reset char_count");
      chk_val(int'(byte_count), 0, "R11 reset byte_count");
      @(posedge clk); #1;
   endtask

   task automatic t_ascii();
      int b = q_n;
      send(8'h41, 1'b0);
      send(8'h7F, 1'b0);
      drain();
      chk_num(b, 2, "R1");
      chk_tok(b, 21'h41, 1, 1'b0, 1'b0, "R1");
      chk_tok(b + 1, 21'h7F, 1, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_multi();
      int b = q_n;
      send(8'hC3, 1'b0); send(8'hA9, 1'b0);
      send(8'hE2, 1'b0); send(8'h82, 1'b0); send(8'hAC, 1'b0);
      drain();
      chk_num(b, 2, "R2");
      chk_tok(b, 21'hE9, 2, 1'b0, 1'b0, "R2");
      chk_tok(b + 1, 21'h20AC, 3, 1'b0, 1'b0, "R2");
   endtask

   task automatic t_four();
      int b = q_n;
      send(8'hF0, 1'b0); send(8'h9F, 1'b0); send(8'h98, 1'b0); send(8'h80, 1'b0);
      send(8'hF4, 1'b0); send(8'h8F, 1'b0); send(8'hBF, 1'b0); send(8'hBF, 1'b0);
      drain();
      chk_num(b, 2, "R3");
      chk_tok(b, 21'h1F600, 4, 1'b0, 1'b0, "R3");
      chk_tok(b + 1, 21'h10FFFF, 4, 1'b0, 1'b0, "R3");
   endtask

   task automatic t_stray();
      int b = q_n;
      send(8'h80, 1'b0); send(8'hC0, 1'b0); send(8'hFF, 1'b0); send(8'hF5, 1'b0);
      drain();
      chk_num(b, 4, "R4");
      chk_tok(b, 21'h80, 1, 1'b1, 1'b0, "R4");
      chk_tok(b + 1, 21'hC0, 1, 1'b1, 1'b0, "R4");
      chk_tok(b + 2, 21'hFF, 1, 1'b1, 1'b0, "R4");
      chk_tok(b + 3, 21'hF5, 1, 1'b1, 1'b0, "R4");
   endtask

   task automatic t_reject();
      int b = q_n;
      send(8'hE0, 1'b0); send(8'h80, 1'b0);
      send(8'hED, 1'b0); send(8'hA0, 1'b0);
      send(8'hF4, 1'b0); send(8'h90, 1'b0);
      send(8'hF0, 1'b0); send(8'h8F, 1'b0);
      drain();
      chk_num(b, 8, "R5");
      chk_tok(b, 21'hE0, 1, 1'b1, 1'b0, "R5 overlong lead");
      chk_tok(b + 1, 21'h80, 1, 1'b1, 1'b0, "R5 overlong second");
      chk_tok(b + 2, 21'hED, 1, 1'b1, 1'b0, "R5 surrogate lead");
      chk_tok(b + 3, 21'hA0, 1, 1'b1, 1'b0, "R5 surrogate second");
      chk_tok(b + 4, 21'hF4, 1, 1'b1, 1'b0, "R5 range lead");
      chk_tok(b + 5, 21'h90, 1, 1'b1, 1'b0, "R5 range second");
      chk_tok(b + 6, 21'hF0, 1, 1'b1, 1'b0, "R5 overlong4 lead");
      chk_tok(b + 7, 21'h8F, 1, 1'b1, 1'b0, "R5 overlong4 second");
   endtask

   task automatic t_break();
      int b = q_n;
      send(8'hE2, 1'b0); send(8'h82, 1'b0); send(8'h41, 1'b0);
      send(8'hC3, 1'b0); send(8'hC3, 1'b0); send(8'hA9, 1'b0);
      drain();
      chk_num(b, 5, "R6");
      chk_tok(b, 21'hE2, 1, 1'b1, 1'b0, "R6 held 1");
      chk_tok(b + 1, 21'h82, 1, 1'b1, 1'b0, "R6 held 2");
      chk_tok(b + 2, 21'h41, 1, 1'b0, 1'b0, "R6 breaker");
      chk_tok(b + 3, 21'hC3, 1, 1'b1, 1'b0, "R6 lead replay");
      chk_tok(b + 4, 21'hE9, 2, 1'b0, 1'b0, "R6 new lead decodes");
   endtask

   task automatic t_nul();
      int b = q_n;
      send(8'hF0, 1'b0); send(8'h9F, 1'b0); send(8'h00, 1'b0);
      drain();
      chk_num(b, 3, "R7");
      chk_tok(b, 21'hF0, 1, 1'b1, 1'b0, "R7");
      chk_tok(b + 1, 21'h9F, 1, 1'b1, 1'b0, "R7");
      chk_tok(b + 2, 21'h00, 1, 1'b0, 1'b1, "R7");
   endtask

   task automatic t_last();
      int b = q_n;
      send(8'hE2, 1'b0); send(8'h82, 1'b1);
      send(8'hC3, 1'b1);
      drain();
      chk_num(b, 3, "R8");
      chk_tok(b, 21'hE2, 1, 1'b1, 1'b0, "R8");
      chk_tok(b + 1, 21'h82, 1, 1'b1, 1'b1, "R8");
      chk_tok(b + 2, 21'hC3, 1, 1'b1, 1'b1, "R8 lone lead");
   endtask

   task automatic t_count();
      send(8'h00, 1'b0);
      drain();
      send(8'h41, 1'b0);
      send(8'hE2, 1'b0); send(8'h82, 1'b0); send(8'hAC, 1'b1);
      drain();
      chk_val(int'(char_count), 2, "R11 chars");
      chk_val(int'(byte_count), 4, "R11 bytes");
      send(8'h42, 1'b0);
      drain();
      chk_val(int'(char_count), 1, "R11 restart chars");
      chk_val(int'(byte_count), 1, "R11 restart bytes");
   endtask

   task automatic t_stall();
      int b = q_n;
      logic [20:0] first;
      out_ready = 1'b0;
      send(8'h5A, 1'b0);
      @(negedge clk);
      first = out_cp;
      chk_val(int'(out_valid), 1, "R10 valid while stalled");
      repeat (3) @(negedge clk);
      chk_val(int'(out_valid), 1, "R10 valid held");
      chk_val(int'(out_cp), int'(first), "R10 cp held");
      chk_val(int'(out_cp), 'h5A, "R10 cp value");
      @(posedge clk); #1;
      out_ready = 1'b1;
      drain();
      chk_num(b, 1, "R10 one token after release");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_ascii();
      t_multi();
      t_four();
      t_stray();
      t_reject();
      t_break();
      t_nul();
      t_last();
      t_count();
      t_stall();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule